// File: doc/BRIEF.md
# Crosspoint Routing Control Interface

This block is the digital control front end of an 8-source, 4-destination routing matrix. A host sends configuration over a three-line serial link: an active-low frame select, a serial clock and a serial data line. Received bits collect in a staging bank that software can overwrite at will. A separate commit strobe copies the staging bank into the live per-destination route registers, and only those registers drive the matrix. Each live route is a 3-bit source index plus an enable. The serial data output repeats the oldest bit of the staging shift register, so several devices can share one data stream.

A format pin picks one of two word layouts. In frame format, one 16-bit frame rewrites every destination at once. In addressed format, a 6-bit word rewrites a single destination. Two level-sensitive override pins act apart from the serial link. One forces every register to a disabled, source-0 state. The other routes source 0 to every destination while it is held. All seven control pins are asynchronous to the fast system clock, and each passes through a two-stage synchronizer before any edge is detected.

Top module: `xbar_route_ctl`

## Requirements
- R1: While `frame_n` is high, serial clock and data activity does not alter the staged configuration; a commit afterwards leaves the routes as they were.
- R2: With `addr_mode` low, a 16-bit frame is received first-bit-first. Destination k uses frame bits 4k..4k+2 as its source index (LSB first) and bit 4k+3 as an enable, where 0 means on and 1 means off.
- R3: With `addr_mode` high, a 6-bit word is received first-bit-first. Bits 0..1 are the destination index (LSB first), bits 2..4 are the source index (LSB first) and bit 5 is an off flag (1 = off, 0 = on). Only that destination's staged route changes.
- R4: Staged data reaches `route_sel`/`route_en` only on a rising edge of `commit`. The commit works whatever the level of `frame_n`.
- R5: An addressed word is accepted only when a rising `sck` edge occurs after `frame_n` has gone high. A word of fewer than 6 bits is discarded, and a commit after it changes nothing.
- R6: In frame format the staging register shifts continuously. `sdo` updates on rising `sck` edges, so the first bit of a stream appears on `sdo` ahead of the 17th sampling edge, and the last 16 bits received form the staged frame.
- R7: While `all_off` is high, all routes and all staged routes become disabled with source 0. A commit after release keeps them disabled.
- R8: While `bcast` is high and `all_off` is low, every destination is enabled on source 0. The live routes return when `bcast` drops.
- R9: When `all_off` and `bcast` are both high, every destination is disabled.
- R10: After system reset, all routes are disabled with source 0 and `sdo` is 0.
- R11: After `frame_n` falls, data is not sampled until the first rising `sck` edge has been seen. A falling edge before that edge is ignored. Each data bit is then sampled on a falling `sck` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the control pins |
| rst | input | 1 | Synchronous active-high system reset |
| frame_n | input | 1 | Active-low serial frame select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| commit | input | 1 | Rising edge moves staged routes to live routes |
| addr_mode | input | 1 | 0 = 16-bit frame format, 1 = 6-bit addressed format |
| all_off | input | 1 | Level override: disable and clear all routes |
| bcast | input | 1 | Level override: route source 0 to every destination |
| route_sel | output | 12 | Source index per destination, 3 bits each, destination 0 in the low bits |
| route_en | output | 4 | Enable per destination, bit k for destination k |

## Verification
The embedded properties check the following on every cycle:
- The staging shift register holds still while the frame is deselected.
- `sdo` moves only on a detected serial clock rise.
- The live routes change only after a detected commit edge.
- `all_off` clears the live bank.
- The override outputs follow the synchronized pins, with `all_off` taking priority.
- A completed addressed word leaves staged data pending.

The bench covers what needs a whole transaction to show:
- Bit order and field placement in both formats, swept over every destination and source in addressed format.
- Early-fall rejection before arming.
- Discarding of short or uncommitted words.
- The 16-bit delay seen on `sdo` during a 32-bit chained stream.

// File: rtl/xbar_ctl_pkg.sv
package xbar_ctl_pkg;

    parameter int XB_INPUTS  = 8;
    parameter int XB_OUTPUTS = 4;

    localparam int SEL_W   = $clog2(XB_INPUTS);
    localparam int OSEL_W  = $clog2(XB_OUTPUTS);
    localparam int LANE_W  = SEL_W + 1;
    localparam int FRAME_W = XB_OUTPUTS * LANE_W;
    localparam int WORD_W  = OSEL_W + SEL_W + 1;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef struct packed {
        logic             on;
        logic [SEL_W-1:0] src;
    } route_t;

    localparam route_t ROUTE_OFF   = '{on: 1'b0, src: '0};
    localparam route_t ROUTE_BCAST = '{on: 1'b1, src: '0};

    typedef enum logic [1:0] {
        RX_OFF,
        RX_PRIME,
        RX_SHIFT,
        RX_COMMIT
    } rx_state_e;

    // One frame lane: source index in the low bits, active-low enable on top
    function automatic route_t lane_decode(input logic [LANE_W-1:0] lane);
        route_t r;
        r.on  = ~lane[LANE_W-1];
        r.src = lane[SEL_W-1:0];
        return r;
    endfunction

    // Shift register image in which every lane reads as disabled, source 0
    function automatic logic [FRAME_W-1:0] frame_all_off();
        logic [FRAME_W-1:0] f;
        f = '0;
        for (int k = 0; k < XB_OUTPUTS; k++) begin
            f[k*LANE_W + SEL_W] = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/xbar_pin_sync.sv
module xbar_pin_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xbar_serial_rx.sv
module xbar_serial_rx
    import xbar_ctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_s,
    input  logic                      sck_s,
    input  logic                      sdi_s,
    input  logic                      mode_s,
    input  logic                      hold_s,
    input  logic                      xfer_i,
    output logic                      sdo_o,
    output logic                      pending_o,
    output route_t [XB_OUTPUTS-1:0]   stage_o
);

    rx_state_e                state_q;
    logic                     sck_prev_q;
    logic [FRAME_W-1:0]       sr_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     sdo_q;
    logic                     pending_q;
    route_t [XB_OUTPUTS-1:0]  stage_q;

    logic                     sck_rise;
    logic                     sck_fall;
    logic [FRAME_W-1:0]       sr_shift;
    logic [WORD_W-1:0]        word;
    logic [OSEL_W-1:0]        w_dst;
    logic [SEL_W-1:0]         w_src;
    logic                     w_off;
    logic                     word_full;
    route_t [XB_OUTPUTS-1:0]  frame_dec;

    assign sck_rise  = sck_s & ~sck_prev_q;
    assign sck_fall  = ~sck_s & sck_prev_q;
    assign sr_shift  = {sdi_s, sr_q[FRAME_W-1:1]};
    assign word      = sr_q[FRAME_W-1 -: WORD_W];
    assign w_dst     = word[OSEL_W-1:0];
    assign w_src     = word[OSEL_W +: SEL_W];
    assign w_off     = word[WORD_W-1];
    assign word_full = (cnt_q == CNT_W'(WORD_W));

    for (genvar k = 0; k < XB_OUTPUTS; k++) begin : g_lane
        assign frame_dec[k] = lane_decode(sr_shift[k*LANE_W +: LANE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold_s) begin
            state_q   <= RX_OFF;
            sr_q      <= frame_all_off();
            cnt_q     <= '0;
            sdo_q     <= 1'b0;
            pending_q <= 1'b0;
            stage_q   <= {XB_OUTPUTS{ROUTE_OFF}};
        end else begin
            pending_q <= pending_q & ~xfer_i;
            case (state_q)
                RX_OFF: begin
                    if (!cs_s) begin
                        state_q <= RX_PRIME;
                        cnt_q   <= '0;
                    end
                end
                RX_PRIME: begin
                    if (cs_s) begin
                        state_q <= RX_OFF;
                    end else if (sck_rise) begin
                        state_q <= RX_SHIFT;
                        sdo_q   <= sr_q[0];
                    end
                end
                RX_SHIFT: begin
                    if (cs_s) begin
                        state_q <= (mode_s && word_full) ? RX_COMMIT : RX_OFF;
                    end else begin
                        if (sck_rise) begin
                            sdo_q <= sr_q[0];
                        end
                        if (sck_fall) begin
                            sr_q <= sr_shift;
                            if (!word_full) begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                            if (!mode_s) begin
                                stage_q   <= frame_dec;
                                pending_q <= 1'b1;
                            end
                        end
                    end
                end
                RX_COMMIT: begin
                    if (!cs_s) begin
                        state_q <= RX_PRIME;
                        cnt_q   <= '0;
                    end else if (sck_rise) begin
                        stage_q[w_dst] <= route_t'{on: ~w_off, src: w_src};
                        pending_q      <= 1'b1;
                        state_q        <= RX_OFF;
                    end
                end
                default: state_q <= RX_OFF;
            endcase
        end
    end

    assign sdo_o     = sdo_q;
    assign pending_o = pending_q;
    assign stage_o   = stage_q;

    // R1
    cs_idle_keeps_sr_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_s && !hold_s) |=> $stable(sr_q));

    // R6
    sdo_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!sck_rise && !hold_s) |=> $stable(sdo_q));

    // R5
    word_commit_pends_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_COMMIT && cs_s && sck_rise && !hold_s) |=> pending_q);

    // R5
    word_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(WORD_W));

endmodule

// File: rtl/xbar_route_bank.sv
module xbar_route_bank
    import xbar_ctl_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_s,
    input  logic                             hold_s,
    input  logic                             bcast_s,
    input  logic                             pending_i,
    input  route_t [XB_OUTPUTS-1:0]          stage_i,
    output logic                             xfer_o,
    output logic [XB_OUTPUTS*SEL_W-1:0]      route_sel,
    output logic [XB_OUTPUTS-1:0]            route_en
);

    logic                    cfg_prev_q;
    route_t [XB_OUTPUTS-1:0] active_q;

    assign xfer_o = cfg_s & ~cfg_prev_q & pending_i & ~hold_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_prev_q <= 1'b0;
        end else begin
            cfg_prev_q <= cfg_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold_s) begin
            active_q <= {XB_OUTPUTS{ROUTE_OFF}};
        end else if (xfer_o) begin
            active_q <= stage_i;
        end
    end

    for (genvar k = 0; k < XB_OUTPUTS; k++) begin : g_out
        route_t shown;
        always_comb begin
            if (hold_s) begin
                shown = ROUTE_OFF;
            end else if (bcast_s) begin
                shown = ROUTE_BCAST;
            end else begin
                shown = active_q[k];
            end
        end
        assign route_sel[k*SEL_W +: SEL_W] = shown.src;
        assign route_en[k]                 = shown.on;
    end

    // R4
    live_needs_commit_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_prev_q || !cfg_s) && !hold_s) |=> $stable(active_q));

    // R7
    hold_clears_live_chk: assert property (@(posedge clk) disable iff (rst)
        hold_s |=> (active_q == {XB_OUTPUTS{ROUTE_OFF}}));

endmodule

// File: rtl/xbar_route_ctl.sv
module xbar_route_ctl
    import xbar_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_n,
    input  logic                          sck,
    input  logic                          sdi,
    output logic                          sdo,
    input  logic                          commit,
    input  logic                          addr_mode,
    input  logic                          all_off,
    input  logic                          bcast,
    output logic [XB_OUTPUTS*SEL_W-1:0]   route_sel,
    output logic [XB_OUTPUTS-1:0]         route_en
);

    localparam int         PIN_W    = 7;
    localparam logic [6:0] PIN_IDLE = 7'b100_0000;

    logic [PIN_W-1:0] pins_s;
    logic cs_s, sck_s, sdi_s, cfg_s, mode_s, hold_s, bcast_s;
    logic xfer;
    logic pending;
    route_t [XB_OUTPUTS-1:0] stage;

    xbar_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({frame_n, sck, sdi, commit, addr_mode, all_off, bcast}),
        .q   (pins_s)
    );

    assign {cs_s, sck_s, sdi_s, cfg_s, mode_s, hold_s, bcast_s} = pins_s;

    xbar_serial_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (cs_s),
        .sck_s     (sck_s),
        .sdi_s     (sdi_s),
        .mode_s    (mode_s),
        .hold_s    (hold_s),
        .xfer_i    (xfer),
        .sdo_o     (sdo),
        .pending_o (pending),
        .stage_o   (stage)
    );

    xbar_route_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_s     (cfg_s),
        .hold_s    (hold_s),
        .bcast_s   (bcast_s),
        .pending_i (pending),
        .stage_i   (stage),
        .xfer_o    (xfer),
        .route_sel (route_sel),
        .route_en  (route_en)
    );

    // R8
    bcast_all_src0_chk: assert property (@(posedge clk) disable iff (rst)
        (bcast_s && !hold_s) |-> (route_en == '1 && route_sel == '0));

    // R9
    hold_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hold_s |-> (route_en == '0 && route_sel == '0));

endmodule

// File: tb/xbar_route_ctl_bench.sv
module xbar_route_ctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        commit = 1'b0;
    logic        addr_mode = 1'b0;
    logic        all_off = 1'b0;
    logic        bcast = 1'b0;
    logic        sdo;
    logic [11:0] route_sel;
    logic [3:0]  route_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [2:0]  act_sel [4];
    logic        act_en  [4];
    logic [2:0]  stg_sel [4];
    logic        stg_en  [4];
    logic        pend;
    logic [31:0] sdo_seen;

    always #4 clk = ~clk;

    xbar_route_ctl u_xbar_route_ctl (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .commit    (commit),
        .addr_mode (addr_mode),
        .all_off   (all_off),
        .bcast     (bcast),
        .route_sel (route_sel),
        .route_en  (route_en)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_bus();
        logic [15:0] v;
        for (int k = 0; k < 4; k++) begin
            v[k*3 +: 3] = act_sel[k];
            v[12 + k]   = act_en[k];
        end
        return v;
    endfunction

    task automatic check_routes(input string req);
        check(req, {16'h0, route_en, route_sel}, {16'h0, exp_bus()});
    endtask

    // frame encoding from R2: lane k = bits 4k..4k+3, enable bit 0 = on
    function automatic logic [15:0] mk_frame(input logic [11:0] sels, input logic [3:0] ens);
        logic [15:0] f;
        for (int k = 0; k < 4; k++) begin
            f[4*k +: 3] = sels[3*k +: 3];
            f[4*k + 3]  = ~ens[k];
        end
        return f;
    endfunction

    task automatic model_frame(input logic [15:0] f);
        for (int k = 0; k < 4; k++) begin
            stg_sel[k] = f[4*k +: 3];
            stg_en[k]  = ~f[4*k + 3];
        end
        pend = 1'b1;
    endtask

    task automatic model_commit();
        if (pend) begin
            for (int k = 0; k < 4; k++) begin
                act_sel[k] = stg_sel[k];
                act_en[k]  = stg_en[k];
            end
            pend = 1'b0;
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) begin
            act_sel[k] = 3'd0; act_en[k] = 1'b0;
            stg_sel[k] = 3'd0; stg_en[k] = 1'b0;
        end
        pend = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n, input bit early_fall);
        if (early_fall) begin
            sck = 1'b1;
            wait_n(4);
        end
        frame_n = 1'b0;
        wait_n(4);
        if (early_fall) begin
            sdi = 1'b1;
            sck = 1'b0;
            wait_n(4);
        end
        sck = 1'b1;
        wait_n(6);
        for (int i = 0; i < n; i++) begin
            sdi = bits[i];
            wait_n(4);
            sdo_seen[i] = sdo;
            sck = 1'b0;
            wait_n(4);
            if (i != n - 1) begin
                sck = 1'b1;
                wait_n(4);
            end
        end
        frame_n = 1'b1;
        wait_n(6);
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        wait_n(6);
        sck = 1'b0;
        wait_n(6);
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        wait_n(4);
        commit = 1'b0;
        wait_n(6);
    endtask

    // addressed word from R3: dst bits 0..1, src bits 2..4, off bit 5
    task automatic send_word(input int dst, input int src, input bit off, input int nbits);
        logic [31:0] w;
        w = '0;
        w[1:0] = 2'(dst);
        w[4:2] = 3'(src);
        w[5]   = off;
        send_bits(w, nbits, 1'b0);
    endtask

    initial begin
        model_clear();
        wait_n(5);
        rst = 1'b0;
        wait_n(4);

        // R10 reset state
        check_routes("R10 routes after reset");
        check("R10 sdo after reset", {31'h0, sdo}, 32'h0);

        // R2 / R4 frame format, commit gating
        addr_mode = 1'b0;
        send_bits({16'h0, mk_frame({3'd1, 3'd7, 3'd2, 3'd5}, 4'b1101)}, 16, 1'b0);
        model_frame(mk_frame({3'd1, 3'd7, 3'd2, 3'd5}, 4'b1101));
        check_routes("R4 no change before commit");
        pulse_commit(); model_commit();
        check_routes("R2 frame applied");

        // R1 activity while deselected is ignored
        for (int i = 0; i < 20; i++) begin
            sdi = i[0] ^ i[2];
            sck = ~sck;
            wait_n(3);
        end
        sck = 1'b0;
        wait_n(4);
        pulse_commit();
        check_routes("R1 deselected activity ignored");

        // R11 early falling edge ignored before arming
        send_bits({16'h0, mk_frame({3'd4, 3'd0, 3'd6, 3'd3}, 4'b1110)}, 16, 1'b1);
        model_frame(mk_frame({3'd4, 3'd0, 3'd6, 3'd3}, 4'b1110));
        pulse_commit(); model_commit();
        check_routes("R11 arming then falling-edge sampling");

        // R3 sweep every destination and source in addressed format
        addr_mode = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 8; s++) begin
                bit off;
                off = ((d + s) % 5) == 0;
                send_word(d, s, off, 6);
                sck_pulse();
                stg_sel[d] = 3'(s); stg_en[d] = ~off; pend = 1'b1;
                pulse_commit(); model_commit();
                check_routes($sformatf("R3 addressed dst %0d src %0d", d, s));
            end
        end

        // R5 no commit without trailing rise, then with it
        send_word(2, 6, 1'b0, 6);
        pulse_commit();
        check_routes("R5 word held without trailing sck rise");
        sck_pulse();
        stg_sel[2] = 3'd6; stg_en[2] = 1'b1; pend = 1'b1;
        // R4 commit while frame select is low
        frame_n = 1'b0;
        wait_n(4);
        pulse_commit(); model_commit();
        frame_n = 1'b1;
        wait_n(6);
        check_routes("R4 commit independent of frame select");

        // R5 short word discarded
        send_word(1, 5, 1'b1, 4);
        sck_pulse();
        pulse_commit();
        check_routes("R5 short word discarded");

        // R6 chained 32-bit stream
        addr_mode = 1'b0;
        begin
            logic [15:0] fa, fb;
            fa = 16'hA5C3;
            fb = mk_frame({3'd2, 3'd0, 3'd7, 3'd7}, 4'b1111);
            send_bits({fb, fa}, 32, 1'b0);
            check("R6 sdo carries first frame 16 bits later", {16'h0, sdo_seen[31:16]}, {16'h0, fa});
            model_frame(fb);
            pulse_commit(); model_commit();
            check_routes("R6 last 16 bits form frame");
        end

        // R8 broadcast override
        bcast = 1'b1;
        wait_n(6);
        check("R8 broadcast", {16'h0, route_en, route_sel}, {16'h0, 4'hF, 12'h000});
        bcast = 1'b0;
        wait_n(6);
        check_routes("R8 routes restored after broadcast");

        // R9 priority of all_off
        all_off = 1'b1;
        bcast = 1'b1;
        wait_n(6);
        check("R9 all_off over bcast", {16'h0, route_en, route_sel}, 32'h0);
        bcast = 1'b0;
        wait_n(6);
        check("R7 all_off held", {16'h0, route_en, route_sel}, 32'h0);
        all_off = 1'b0;
        wait_n(6);
        model_clear();
        check_routes("R7 routes cleared after release");
        pulse_commit();
        check_routes("R7 commit after clear keeps routes off");

        addr_mode = 1'b1;
        send_word(3, 4, 1'b0, 6);
        sck_pulse();
        stg_sel[3] = 3'd4; stg_en[3] = 1'b1; pend = 1'b1;
        pulse_commit(); model_commit();
        check_routes("R3 programming after clear");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule